// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial management bus that gives a host read and write access to a small bank of 8-bit configuration registers. The host addresses it as 0xD2 (write) or 0xD3 (read) and then sends a command byte. The top bit of that byte picks one of two access styles. A block access runs through the registers from index 0 upward and carries a byte count. An indexed byte or word access starts at the register offset held in the command's low seven bits.

The slave samples SCL and SDA through a two-stage synchronizer. It detects start, repeated start and stop, and drives SDA only as an open-drain pull-down. It generates the acknowledge for each byte it accepts. The register storage sits outside the block, behind a plain parallel port: a one-cycle write strobe with address and data, and a combinational read address with read data.

Top module: `smbus_regfile_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 and 0xD3 (7-bit address 1101001, LSB 0 = write, 1 = read). On any other address it does not acknowledge, and it leaves SDA released for the rest of the transfer until the next start condition.
- R2: A command byte with bit 7 = 0 selects a block access and sets the register pointer to 0, whatever bits 6:0 hold. A command byte with bit 7 = 1 selects an indexed access and sets the pointer to bits 6:0.
- R3: In a block write, the byte after the command is a count. The slave acknowledges the next min(count, NUM_REGS) data bytes and stores them in registers 0, 1, 2 and so on. It does not acknowledge any further data byte and does not store it.
- R4: Each accepted data byte reaches the register file as a single regWrEn pulse on the acknowledge clock of that byte. A host that stops after any complete byte keeps every byte already acknowledged.
- R5: An indexed write accepts at most two data bytes (byte or word), stored at offset and offset+1. A third data byte is not acknowledged and not stored.
- R6: A block read is a command write, a repeated start, and then 0xD3. The slave returns NUM_REGS as the first byte, then registers 0, 1, 2 and so on while the host acknowledges. After a not-acknowledge it releases SDA.
- R7: An indexed read, made with a repeated start after the command, returns the register at the offset and then the register at offset+1 if the host acknowledges (word).
- R8: An offset at or above NUM_REGS reads as 0x00. A write to such an offset is acknowledged but produces no regWrEn pulse.
- R9: The slave changes its SDA drive only while SCL is low. Start and stop are recognised only as SDA edges while SCL is high.
- R10: After reset, sdaOe is 0 and no register write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 3 | Register write index |
| regWrData | output | 8 | Register write data |
| regRdAddr | output | 3 | Register read index |
| regRdData | input | 8 | Register read data (combinational from regRdAddr) |

## Verification
The bench targets the boundaries of the transfer rules. It sends a word write that starts at the last register, where a design with an unchecked pointer would alias onto register 0. It sends a block-write count larger than the bank, where a slave without a limit would keep acknowledging. It sends a third byte to an indexed write, which a slave without a per-access limit would store. It stops a block write after two bytes, which exposes a slave that commits only at stop. It also issues a foreign address and a block command with non-zero low bits, where a lax decoder would answer or would start from the wrong register. A monitor flags any SDA change while SCL is high, which would show a slave that drives data on the wrong clock phase.

// File: rtl/smbus_slv_pkg.sv
package smbus_slv_pkg;

  // Strobes and levels from the control FSM to the datapath
  typedef struct packed {
    logic ptrLoad;    // set pointer from the command byte
    logic wrCommit;   // accepted data byte: write and advance
    logic loadCount;  // load the bank size as the next transmit byte
    logic loadData;   // load register at pointer for transmit, advance
    logic txMode;     // slave is the transmitter of the current byte
    logic ackNext;    // slave will drive an ack on the coming ack clock
  } ctrlStrobe_t;

  // Bus events from the datapath to the control FSM
  typedef struct packed {
    logic       startDet;
    logic       stopDet;
    logic       byteRx;    // eighth data bit sampled
    logic       frameEnd;  // ninth (ack) bit sampled
    logic       sdaBit;    // SDA value at this rising edge
    logic [7:0] rxByte;
  } busEvent_t;

endpackage

// File: rtl/smbus_sync.sv
module smbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;  // idle bus level
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/smbus_slv_dp.sv
module smbus_slv_dp
  import smbus_slv_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrobe_t       ctl,
  output busEvent_t         ev,
  output logic              sdaOe,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [7:0]        regRdData
);
  localparam logic [8:0] REG_CNT = 9'(NUM_REGS);

  logic [1:0] rawIn, syncOut;
  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    smbus_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[g]),
      .q   (syncOut[g])
    );
  end

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = syncOut[1];
  assign sdaS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // Bit position within the nine-clock frame
  logic [3:0] bitCnt;
  logic [7:0] shiftQ, shiftNext;
  assign shiftNext = {shiftQ[6:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shiftQ <= '0;
    end else if (startDet || stopDet) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt == 4'd8) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 4'd1;
        shiftQ <= shiftNext;
      end
    end
  end

  assign ev.startDet = startDet;
  assign ev.stopDet  = stopDet;
  assign ev.byteRx   = sclRise && (bitCnt == 4'd7);
  assign ev.frameEnd = sclRise && (bitCnt == 4'd8);
  assign ev.sdaBit   = sdaS;
  assign ev.rxByte   = (bitCnt == 4'd7) ? shiftNext : shiftQ;

  // Register pointer and transmit byte
  logic [7:0] ptrQ, txQ, rdVal, ptrInc;
  logic       ptrHit;
  assign ptrHit = {1'b0, ptrQ} < REG_CNT;
  assign rdVal  = ptrHit ? regRdData : 8'h00;
  assign ptrInc = (ptrQ == 8'hFF) ? ptrQ : ptrQ + 8'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      txQ  <= '0;
    end else begin
      if (ctl.ptrLoad)
        ptrQ <= ev.rxByte[7] ? {1'b0, ev.rxByte[6:0]} : 8'h00;
      else if (ctl.wrCommit || ctl.loadData)
        ptrQ <= ptrInc;
      if (ctl.loadCount)     txQ <= REG_CNT[7:0];
      else if (ctl.loadData) txQ <= rdVal;
    end
  end

  // Open-drain drive, updated only on a falling SCL edge
  logic sdaOeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOeQ <= 1'b0;
    end else if (sclFall) begin
      if (bitCnt == 4'd8) sdaOeQ <= ~ctl.txMode & ctl.ackNext;
      else                sdaOeQ <= ctl.txMode & ~txQ[3'd7 - bitCnt[2:0]];
    end
  end

  assign sdaOe     = sdaOeQ;
  assign regWrEn   = ctl.wrCommit & ptrHit;
  assign regWrAddr = ptrQ[ADDR_W-1:0];
  assign regWrData = shiftQ;
  assign regRdAddr = ptrQ[ADDR_W-1:0];

  // SDA drive moves only while the synchronized clock is low
  assert_sda_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOeQ) |-> !sclS);

  // A write strobe coincides with the slave's own ack on the line
  assert_write_on_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> sdaOeQ);

  // The frame counter never leaves the nine-bit frame
  assert_frame_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);

endmodule

// File: rtl/smbus_slv_ctrl.sv
module smbus_slv_ctrl
  import smbus_slv_pkg::*;
#(
  parameter int         NUM_REGS   = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   ev,
  output ctrlStrobe_t ctl
);
  localparam logic [8:0] REG_CNT = 9'(NUM_REGS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA, ST_TX
  } state_t;

  state_t     stateQ;
  logic       ackQ, rwQ, blockQ;
  logic [7:0] leftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      ackQ   <= 1'b0;
      rwQ    <= 1'b0;
      blockQ <= 1'b1;
      leftQ  <= '0;
    end else if (ev.startDet) begin
      stateQ <= ST_ADDR;
      ackQ   <= 1'b0;
    end else if (ev.stopDet) begin
      stateQ <= ST_IDLE;
      ackQ   <= 1'b0;
    end else if (ev.byteRx) begin
      case (stateQ)
        ST_ADDR: begin
          ackQ <= (ev.rxByte[7:1] == SLAVE_ADDR);
          rwQ  <= ev.rxByte[0];
        end
        ST_CMD, ST_COUNT: ackQ <= 1'b1;
        ST_WDATA:         ackQ <= (leftQ != 8'd0);
        default:          ackQ <= 1'b0;
      endcase
    end else if (ev.frameEnd) begin
      ackQ <= 1'b0;
      case (stateQ)
        ST_ADDR: begin
          if (!ackQ)     stateQ <= ST_IDLE;
          else if (!rwQ) stateQ <= ST_CMD;
          else           stateQ <= ST_TX;
        end
        ST_CMD: begin
          blockQ <= ~ev.rxByte[7];
          if (ev.rxByte[7]) begin
            stateQ <= ST_WDATA;
            leftQ  <= 8'd2;
          end else begin
            stateQ <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          leftQ  <= ({1'b0, ev.rxByte} > REG_CNT) ? REG_CNT[7:0] : ev.rxByte;
          stateQ <= ST_WDATA;
        end
        ST_WDATA: begin
          if (ackQ) leftQ  <= leftQ - 8'd1;
          else      stateQ <= ST_IDLE;
        end
        ST_TX: if (ev.sdaBit) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  logic addrOk;
  assign addrOk = ev.frameEnd && (stateQ == ST_ADDR) && ackQ && rwQ;

  assign ctl.ptrLoad   = ev.frameEnd && (stateQ == ST_CMD);
  assign ctl.wrCommit  = ev.frameEnd && (stateQ == ST_WDATA) && ackQ;
  assign ctl.loadCount = addrOk && blockQ;
  assign ctl.loadData  = (addrOk && !blockQ) ||
                         (ev.frameEnd && (stateQ == ST_TX) && !ev.sdaBit);
  assign ctl.txMode    = (stateQ == ST_TX);
  assign ctl.ackNext   = ackQ;

  // A foreign address byte is never acknowledged
  assert_addr_mismatch_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR && ev.byteRx && ev.rxByte[7:1] != SLAVE_ADDR) |=> !ackQ);

  // Datapath strobes never collide
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ptrLoad, ctl.wrCommit, ctl.loadCount, ctl.loadData}));

  // Leaving the write phase on a refused byte only from a zero budget
  assert_write_budget_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WDATA && ev.byteRx && leftQ == 8'd0) |=> !ackQ);

endmodule

// File: rtl/smbus_regfile_slave.sv
module smbus_regfile_slave #(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2,
  localparam int        ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [7:0]        regRdData
);
  import smbus_slv_pkg::*;

  ctrlStrobe_t ctl;
  busEvent_t   ev;

  smbus_slv_dp #(
    .NUM_REGS   (NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_W     (ADDR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ctl      (ctl),
    .ev       (ev),
    .sdaOe    (sdaOe),
    .regWrEn  (regWrEn),
    .regWrAddr(regWrAddr),
    .regWrData(regWrData),
    .regRdAddr(regRdAddr),
    .regRdData(regRdData)
  );

  smbus_slv_ctrl #(
    .NUM_REGS  (NUM_REGS),
    .SLAVE_ADDR(SLAVE_ADDR)
  ) uCtrl (
    .clk (clk),
    .rstN(rstN),
    .ev  (ev),
    .ctl (ctl)
  );

endmodule

// File: tb/tb_smbus_regfile_slave.sv
module tb_smbus_regfile_slave;
  localparam int NUM_REGS = 8;
  localparam int Q = 10;  // quarter SCL period in clk cycles

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rstN;
  logic       sclDrv = 1'b1, sdaDrv = 1'b1;
  logic       sdaOe, sdaLine, regWrEn;
  logic [2:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;

  assign sdaLine = sdaDrv & ~sdaOe;

  smbus_regfile_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  // External register bank model
  logic [7:0] mem [NUM_REGS];
  int wrCount = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
    end else if (regWrEn) begin
      mem[regWrAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end
  assign regRdData = mem[regRdAddr];

  int   checks = 0, failures = 0;
  bit   finished = 0;
  int   badPhase = 0, oeWhileForeign = 0;
  bit   watchForeign = 0;
  logic prevOe = 1'b0;

  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevOe) && sclDrv) badPhase++;
    if (watchForeign && sdaOe) oeWhileForeign++;
    prevOe = sdaOe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sdaDrv = 1'b0; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic stopC();
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sdaDrv = 1'b1; tick(2*Q);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    b = sdaLine; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic readByte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    sendBit(nack);
  endtask

  logic [7:0] wBuf [16];
  logic [7:0] rBuf [16];
  logic       ackBuf [16];
  logic       addrAck, cmdAck, rdAddrAck;

  task automatic busWrite(input logic [7:0] cmd, input int n);
    startC();
    writeByte(8'hD2, addrAck);
    writeByte(cmd, cmdAck);
    for (int i = 0; i < n; i++) writeByte(wBuf[i], ackBuf[i]);
    stopC();
  endtask

  task automatic busRead(input logic [7:0] cmd, input int n);
    startC();
    writeByte(8'hD2, addrAck);
    writeByte(cmd, cmdAck);
    startC();
    writeByte(8'hD3, rdAddrAck);
    for (int i = 0; i < n; i++) readByte(i == n - 1, rBuf[i]);
    stopC();
  endtask

  // {offset, data0, data1, expect0, expect1, write strobes}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'h11, 8'h22, 8'h11, 8'h22, 8'd2},
    {8'h03, 8'h33, 8'h44, 8'h33, 8'h44, 8'd2},
    {8'h06, 8'h55, 8'h66, 8'h55, 8'h66, 8'd2},
    {8'h07, 8'h77, 8'h88, 8'h77, 8'h00, 8'd1},
    {8'h40, 8'h99, 8'hAA, 8'h00, 8'h00, 8'd0},
    {8'h02, 8'h5A, 8'hA5, 8'h5A, 8'hA5, 8'd2}
  };

  task automatic finishRun();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=done");
      finishRun();
    end
  end

  logic [7:0] offV, d0V, d1V, e0V, e1V, nWrV;
  int         w0;
  logic [7:0] blkExp [NUM_REGS];
  logic       fa0, fa1, fa2;

  initial begin
    rstN = 1'b0;
    tick(10);
    chk("R10 sdaOe in reset", sdaOe, 1'b0);
    rstN = 1'b1;
    tick(20);
    chk("R10 sdaOe after reset", sdaOe, 1'b0);
    chk("R10 no write after reset", wrCount, 0);

    // Table of indexed word writes and read-backs
    for (int i = 0; i < 6; i++) begin
      {offV, d0V, d1V, e0V, e1V, nWrV} = VEC[i];
      w0 = wrCount;
      wBuf[0] = d0V; wBuf[1] = d1V;
      busWrite(8'h80 | offV, 2);
      chk("R1 R5 word write acks", {addrAck, cmdAck, ackBuf[0], ackBuf[1]}, 4'hF);
      chk("R8 R4 write strobe count", wrCount - w0, 32'(nWrV));
      busRead(8'h80 | offV, 2);
      chk("R1 read address ack", rdAddrAck, 1'b1);
      chk("R7 R8 first read byte", rBuf[0], e0V);
      chk("R7 R8 second read byte", rBuf[1], e1V);
    end

    // R6: block read of the whole bank
    blkExp = '{8'h11, 8'h22, 8'h5A, 8'hA5, 8'h44, 8'h00, 8'h55, 8'h77};
    busRead(8'h00, NUM_REGS + 1);
    chk("R6 byte count", rBuf[0], 8'(NUM_REGS));
    for (int i = 0; i < NUM_REGS; i++) chk("R6 block read data", rBuf[i+1], blkExp[i]);
    chk("R6 released after nack", sdaOe, 1'b0);

    // R3: count 3 with a fourth data byte
    w0 = wrCount;
    wBuf[0] = 8'd3; wBuf[1] = 8'hA0; wBuf[2] = 8'hA1; wBuf[3] = 8'hA2; wBuf[4] = 8'hA3;
    busWrite(8'h00, 5);
    chk("R3 count and data acks", {ackBuf[0], ackBuf[1], ackBuf[2], ackBuf[3]}, 4'hF);
    chk("R3 excess byte refused", ackBuf[4], 1'b0);
    chk("R3 strobes", wrCount - w0, 3);

    // R4: count 5 but stop after two bytes
    w0 = wrCount;
    wBuf[0] = 8'd5; wBuf[1] = 8'hE0; wBuf[2] = 8'hE1;
    busWrite(8'h00, 3);
    chk("R4 early stop strobes", wrCount - w0, 2);
    // R2: block command with non-zero low bits still starts at 0
    busRead(8'h05, 5);
    chk("R2 count", rBuf[0], 8'(NUM_REGS));
    chk("R4 reg0 kept", rBuf[1], 8'hE0);
    chk("R4 reg1 kept", rBuf[2], 8'hE1);
    chk("R3 reg2 from earlier block", rBuf[3], 8'hA2);
    chk("R3 reg3 untouched by excess", rBuf[4], 8'hA5);

    // R3: count larger than the bank
    w0 = wrCount;
    wBuf[0] = 8'd10;
    for (int i = 0; i < 10; i++) wBuf[i+1] = 8'hC0 + 8'(i);
    busWrite(8'h00, 11);
    chk("R3 last in-bank byte acked", ackBuf[NUM_REGS], 1'b1);
    chk("R3 byte past bank refused", ackBuf[NUM_REGS+1], 1'b0);
    chk("R3 capped strobes", wrCount - w0, NUM_REGS);
    busRead(8'h00, NUM_REGS + 1);
    for (int i = 0; i < NUM_REGS; i++) chk("R3 capped block data", rBuf[i+1], 8'hC0 + 8'(i));

    // R7: single indexed byte read
    busRead(8'h85, 1);
    chk("R7 byte read", rBuf[0], 8'hC5);

    // R5: third byte on an indexed write
    w0 = wrCount;
    wBuf[0] = 8'h1A; wBuf[1] = 8'h1B; wBuf[2] = 8'h1C;
    busWrite(8'h81, 3);
    chk("R5 two bytes acked", {ackBuf[0], ackBuf[1]}, 2'b11);
    chk("R5 third byte refused", ackBuf[2], 1'b0);
    chk("R5 strobes", wrCount - w0, 2);
    busRead(8'h81, 3);
    chk("R5 reg1", rBuf[0], 8'h1A);
    chk("R5 reg2", rBuf[1], 8'h1B);
    chk("R5 reg3 untouched", rBuf[2], 8'hC3);

    // R1: foreign address is ignored until the next start
    w0 = wrCount;
    startC();
    watchForeign = 1;
    writeByte(8'hA4, fa0);
    writeByte(8'h81, fa1);
    writeByte(8'h55, fa2);
    watchForeign = 0;
    stopC();
    chk("R1 foreign address no ack", fa0, 1'b0);
    chk("R1 following bytes no ack", {fa1, fa2}, 2'b00);
    chk("R1 SDA never driven", oeWhileForeign, 0);
    chk("R1 no write from foreign", wrCount - w0, 0);
    busRead(8'h81, 1);
    chk("R1 responds after next start", {addrAck, rBuf[0]}, {1'b1, 8'h1A});

    tick(20);
    chk("R9 no SDA change while SCL high", badPhase, 0);
    finishRun();
  end
endmodule